// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the source and destination access addresses for a single DMA channel. Each side has a software-programmable address register and a separate working address that the channel actually uses. When a transfer request is accepted, both working addresses are loaded from the programmed values. Every access then moves the working address on the side that was accessed. It can move up, move down or stay put, and the step is the configured transfer size.

The programmed registers are deliberately not live. They receive the working addresses only when a block unit completes. Software that reads them in the middle of a block therefore sees the value from before the block started, and software writes during a block are dropped. In fly-by operation only the destination side is loaded, stepped and written back, and the source side stays as it was. The counting directions, the transfer size and the fly-by flag are captured when the request is accepted and are held for the whole block. Bus cycles are generated elsewhere; this block only supplies the addresses.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, both programmed registers and both working addresses are 0 and `busy` is 0.
- R2: A `start` pulse while `busy` is 0 loads each working address from its programmed register and sets `busy`. The new values are visible on the outputs after that clock edge.
- R3: With direction code 2'b00, each step pulse adds the transfer size to that side's working address. Size code 2'b00 means 1 byte, 2'b01 means 2 bytes, and 2'b10 or 2'b11 mean 4 bytes.
- R4: With direction code 2'b01, each step pulse subtracts the transfer size from that side's working address.
- R5: With direction code 2'b10 or 2'b11, the working address stays the same on every step of the block.
- R6: The source and destination directions are chosen independently, and each side moves only on its own step input.
- R7: While `busy` is 1, the programmed registers keep their pre-block values on `reg_rdata`. A `block_done` pulse copies each working address into its programmed register and clears `busy`. If a step arrives in the same cycle as `block_done`, the copied value includes that step.
- R8: When fly-by is captured as 1, the source working address and the source programmed register are neither loaded, stepped nor written back.
- R9: Writes to the programmed registers (`reg_sel` 0 selects source, 1 selects destination) take effect when `busy` is 0 and are ignored when `busy` is 1.
- R10: Address arithmetic wraps modulo 2^AW.
- R11: The directions, size and fly-by flag are captured at `start`. Changes to them during a block have no effect on that block.
- R12: Step pulses while `busy` is 0 are ignored, and `start` while `busy` is 1 does not reload the working addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Programmed register write strobe |
| reg_sel | input | 1 | Register select for write and read: 0 source, 1 destination |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Programmed register selected by `reg_sel` |
| src_dir | input | 2 | Source direction: 00 up, 01 down, 1x hold |
| dst_dir | input | 2 | Destination direction: 00 up, 01 down, 1x hold |
| xfer_size | input | 2 | Transfer size: 00 one byte, 01 two, 1x four |
| flyby | input | 1 | Fly-by operation: destination side only |
| start | input | 1 | Transfer request accepted |
| step_src | input | 1 | Source access completed |
| step_dst | input | 1 | Destination access completed |
| block_done | input | 1 | Block unit completed |
| busy | output | 1 | Block in progress |
| src_addr | output | AW | Source working address |
| dst_addr | output | AW | Destination working address |

## Verification
The bench aims at the 32-bit wrap in both directions. A design that saturated or flagged an error there would report the wrong address after the step across zero. It programs registers in the middle of a block and reads them back. An implementation with live registers would return the working value, and one that accepted the write would corrupt the next block's start address. Fly-by blocks are run with step and write-back activity on the source inputs, which catches any leak into the source side. Direction, size and fly-by inputs are also changed in the middle of a block, which catches a design that samples its configuration continuously instead of at `start`.

// File: rtl/dag_pkg.sv
package dag_pkg;

   typedef enum logic [1:0] {
      DIR_UP    = 2'b00,
      DIR_DOWN  = 2'b01,
      DIR_HOLD  = 2'b10,
      DIR_HOLDX = 2'b11
   } dir_e;

   typedef struct packed {
      dir_e       src_dir;
      dir_e       dst_dir;
      logic [1:0] size;
      logic       flyby;
   } cfg_t;

   localparam int unsigned SIDE_SRC = 0;
   localparam int unsigned SIDE_DST = 1;
   localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/dag_stepper.sv
module dag_stepper
   import dag_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned MAX_LOG2 = 2
) (
   input  logic [AW-1:0] addr_i,
   input  dir_e          dir_i,
   input  logic [1:0]    size_i,
   output logic [AW-1:0] addr_o
);

   localparam logic [1:0] SIZE_CAP = 2'(MAX_LOG2);

   logic [1:0]    size_eff;
   logic [AW-1:0] delta;

   generate
      if (MAX_LOG2 > 3) begin : g_bad
         $error("dag_stepper: MAX_LOG2 must be 0..3");
      end
      if (MAX_LOG2 == 0) begin : g_bytewide
         assign size_eff = 2'b00;
      end else begin : g_sized
         assign size_eff = (size_i > SIZE_CAP) ? SIZE_CAP : size_i;
      end
   endgenerate

   assign delta = {{(AW-1){1'b0}}, 1'b1} << size_eff;

   always_comb begin
      unique case (dir_i)
         DIR_UP:   addr_o = addr_i + delta;
         DIR_DOWN: addr_o = addr_i - delta;
         default:  addr_o = addr_i;
      endcase
   end

endmodule

// File: rtl/dag_side.sv
module dag_side
   import dag_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned MAX_LOG2 = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data,
   input  logic          load,
   input  logic          step,
   input  logic          commit,
   input  dir_e          dir,
   input  logic [1:0]    size,
   output logic [AW-1:0] prog_q,
   output logic [AW-1:0] work_q
);

   logic [AW-1:0] stepped;
   logic [AW-1:0] work_nxt;

   dag_stepper #(.AW(AW), .MAX_LOG2(MAX_LOG2)) u_step (
      .addr_i (work_q),
      .dir_i  (dir),
      .size_i (size),
      .addr_o (stepped)
   );

   assign work_nxt = step ? stepped : work_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
      end else if (load) begin
         work_q <= prog_q;
      end else begin
         work_q <= work_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= '0;
      end else if (commit) begin
         prog_q <= work_nxt;
      end else if (wr_en) begin
         prog_q <= wr_data;
      end
   end

   // R2: a load copies the programmed value into the working copy
   a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> work_q == $past(prog_q));

   // R7: after a write-back, register and working copy agree
   a_r7_commit_sync: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> prog_q == work_q);

   // R7/R9: the programmed register changes only on write or write-back
   a_r7_prog_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !wr_en) |=> $stable(prog_q));

   // R5: hold direction never moves the working copy
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && dir[1]) |=> $stable(work_q));

endmodule

// File: rtl/dag_ctrl.sv
module dag_ctrl
   import dag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       block_done,
   input  logic       step_src,
   input  logic       step_dst,
   input  logic       reg_we,
   input  logic       reg_sel,
   input  cfg_t       cfg_in,
   output cfg_t       cfg_q,
   output logic       busy_q,
   output logic [NUM_SIDES-1:0] load,
   output logic [NUM_SIDES-1:0] step,
   output logic [NUM_SIDES-1:0] commit,
   output logic [NUM_SIDES-1:0] wr
);

   logic accept;
   logic finish;

   assign accept = start && !busy_q;
   assign finish = block_done && busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cfg_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cfg_q  <= cfg_in;
      end else if (finish) begin
         busy_q <= 1'b0;
      end
   end

   always_comb begin
      load[SIDE_DST]   = accept;
      load[SIDE_SRC]   = accept && !cfg_in.flyby;
      step[SIDE_DST]   = busy_q && step_dst;
      step[SIDE_SRC]   = busy_q && step_src && !cfg_q.flyby;
      commit[SIDE_DST] = finish;
      commit[SIDE_SRC] = finish && !cfg_q.flyby;
      wr[SIDE_DST]     = reg_we && !busy_q && reg_sel;
      wr[SIDE_SRC]     = reg_we && !busy_q && !reg_sel;
   end

   // R11: configuration is held for the whole block
   a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !finish) |=> busy_q && $stable(cfg_q));

   // R12: a request while busy is not accepted
   a_r12_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> load == '0);

   // R9: no register write strobe while a block runs
   a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> wr == '0);

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dag_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned MAX_LOG2 = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic          reg_sel,
   input  logic [AW-1:0] reg_wdata,
   output logic [AW-1:0] reg_rdata,
   input  logic [1:0]    src_dir,
   input  logic [1:0]    dst_dir,
   input  logic [1:0]    xfer_size,
   input  logic          flyby,
   input  logic          start,
   input  logic          step_src,
   input  logic          step_dst,
   input  logic          block_done,
   output logic          busy,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] dst_addr
);

   generate
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("dma_addr_gen: AW must be 8..64");
      end
   endgenerate

   cfg_t cfg_in;
   cfg_t cfg_q;
   logic [NUM_SIDES-1:0] load, step, commit, wr;
   logic [AW-1:0] prog [NUM_SIDES];
   logic [AW-1:0] work [NUM_SIDES];
   dir_e side_dir [NUM_SIDES];

   always_comb begin
      cfg_in.src_dir = dir_e'(src_dir);
      cfg_in.dst_dir = dir_e'(dst_dir);
      cfg_in.size    = xfer_size;
      cfg_in.flyby   = flyby;
   end

   dag_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .block_done (block_done),
      .step_src   (step_src),
      .step_dst   (step_dst),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .cfg_in     (cfg_in),
      .cfg_q      (cfg_q),
      .busy_q     (busy),
      .load       (load),
      .step       (step),
      .commit     (commit),
      .wr         (wr)
   );

   assign side_dir[SIDE_SRC] = cfg_q.src_dir;
   assign side_dir[SIDE_DST] = cfg_q.dst_dir;

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      dag_side #(.AW(AW), .MAX_LOG2(MAX_LOG2)) u_side (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr[s]),
         .wr_data (reg_wdata),
         .load    (load[s]),
         .step    (step[s]),
         .commit  (commit[s]),
         .dir     (side_dir[s]),
         .size    (cfg_q.size),
         .prog_q  (prog[s]),
         .work_q  (work[s])
      );
   end

   assign src_addr  = work[SIDE_SRC];
   assign dst_addr  = work[SIDE_DST];
   assign reg_rdata = reg_sel ? prog[SIDE_DST] : prog[SIDE_SRC];

   // R8: during a fly-by block the source side does not move
   a_r8_flyby_src_still: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_q.flyby) |=> $stable(src_addr) && $stable(prog[SIDE_SRC]));

   // R12: idle step pulses leave the working copies alone
   a_r12_idle_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(src_addr) && $stable(dst_addr));

endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0, reg_sel = 1'b0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic [1:0]    src_dir = 2'b00, dst_dir = 2'b00, xfer_size = 2'b00;
   logic          flyby = 1'b0, start = 1'b0, step_src = 1'b0, step_dst = 1'b0, block_done = 1'b0;
   logic          busy;
   logic [AW-1:0] src_addr, dst_addr;

   int errors = 0;
   int checks = 0;
   bit done_flag = 0;

   // model state
   logic [AW-1:0] m_ps = '0, m_pd = '0, m_ws = '0, m_wd = '0;
   logic          m_busy = 1'b0;
   logic [1:0]    m_sd = 0, m_dd = 0, m_sz = 0;
   logic          m_fly = 1'b0;

   always #10 clk = ~clk;

   dma_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_dir(src_dir),
      .dst_dir(dst_dir), .xfer_size(xfer_size), .flyby(flyby), .start(start),
      .step_src(step_src), .step_dst(step_dst), .block_done(block_done),
      .busy(busy), .src_addr(src_addr), .dst_addr(dst_addr)
   );

   function automatic logic [AW-1:0] f_step(logic [AW-1:0] a, logic [1:0] d, logic [1:0] sz);
      logic [AW-1:0] n;
      n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      if (d == 2'b00) return a + n;
      if (d == 2'b01) return a - n;
      return a;
   endfunction

   task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle: drive, update model, compare
   task automatic cyc(input logic we, input logic sel, input logic [AW-1:0] wd,
                      input logic st, input logic ss, input logic sd, input logic bd,
                      input string req);
      logic [AW-1:0] nws, nwd;
      @(negedge clk);
      reg_we = we; reg_sel = sel; reg_wdata = wd;
      start = st; step_src = ss; step_dst = sd; block_done = bd;
      @(posedge clk);
      #1;
      // R2/R3/R4/R5/R6/R7/R8/R9/R11/R12 reference update
      nws = m_ws; nwd = m_wd;
      if (m_busy) begin
         if (ss && !m_fly) nws = f_step(m_ws, m_sd, m_sz);
         if (sd) nwd = f_step(m_wd, m_dd, m_sz);
         m_ws = nws; m_wd = nwd;
         if (bd) begin
            m_pd = nwd;
            if (!m_fly) m_ps = nws;
            m_busy = 1'b0;
         end
      end else begin
         if (st) begin
            if (!flyby) m_ws = m_ps;
            m_wd = m_pd;
            m_sd = src_dir; m_dd = dst_dir; m_sz = xfer_size; m_fly = flyby;
            m_busy = 1'b1;
         end
         if (we) begin
            if (sel) m_pd = wd; else m_ps = wd;
         end
      end
      chk({req, " busy"}, {31'b0, busy}, {31'b0, m_busy});
      chk({req, " src_addr"}, src_addr, m_ws);
      chk({req, " dst_addr"}, dst_addr, m_wd);
      chk({req, " reg_rdata"}, reg_rdata, sel ? m_pd : m_ps);
   endtask

   task automatic set_cfg(logic [1:0] sd, logic [1:0] dd, logic [1:0] sz, logic fb);
      src_dir = sd; dst_dir = dd; xfer_size = sz; flyby = fb;
   endtask

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      #35;
      // R1: reset state
      chk("R1 busy", {31'b0, busy}, 32'd0);
      chk("R1 src_addr", src_addr, 32'd0);
      chk("R1 dst_addr", dst_addr, 32'd0);
      chk("R1 reg_rdata", reg_rdata, 32'd0);
      rst_n = 1'b1;

      // R3 / R10: up-count across wrap with 4-byte size, R4 down across zero
      cyc(1, 0, 32'hFFFF_FFFE, 0, 0, 0, 0, "R9 write src");
      cyc(1, 1, 32'h0000_0002, 0, 0, 0, 0, "R9 write dst");
      set_cfg(2'b00, 2'b01, 2'b10, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, "R2 start");
      cyc(0, 0, 0, 0, 1, 1, 0, "R10 wrap step");
      chk("R10 src wraps up", src_addr, 32'h0000_0002);
      chk("R10 dst wraps down", dst_addr, 32'hFFFF_FFFE);
      // R9 write while busy ignored, R7 stale read
      cyc(1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, "R9 busy write");
      chk("R7 stale src reg", reg_rdata, 32'hFFFF_FFFE);
      // R11 cfg change mid-block
      set_cfg(2'b01, 2'b00, 2'b00, 1);
      cyc(0, 0, 0, 0, 1, 0, 0, "R11 cfg ignored");
      chk("R11 src still up by 4", src_addr, 32'h0000_0006);
      // R7 write-back including same-cycle step
      cyc(0, 1, 0, 0, 0, 1, 1, "R7 done");
      chk("R7 dst writeback", reg_rdata, 32'hFFFF_FFFA);
      cyc(0, 0, 0, 0, 0, 0, 0, "R7 read src");
      chk("R7 src writeback", reg_rdata, 32'h0000_0006);
      // R12 idle steps ignored
      cyc(0, 0, 0, 0, 1, 1, 0, "R12 idle step");
      // R8 fly-by: source untouched
      set_cfg(2'b00, 2'b00, 2'b01, 1);
      cyc(1, 0, 32'h1000, 0, 0, 0, 0, "R8 write src");
      cyc(0, 0, 0, 1, 0, 0, 0, "R8 start");
      cyc(0, 0, 0, 0, 1, 1, 0, "R8 step");
      cyc(0, 0, 0, 1, 1, 1, 1, "R8 done");
      chk("R8 src work untouched", src_addr, 32'h0000_0006);
      chk("R8 src reg untouched", reg_rdata, 32'h0000_1000);
      // R5 fixed on both
      set_cfg(2'b10, 2'b11, 2'b00, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, "R5 start");
      cyc(0, 0, 0, 0, 1, 1, 0, "R5 step");
      cyc(0, 0, 0, 0, 1, 1, 0, "R5 step");
      chk("R5 fixed src", src_addr, 32'h0000_1000);
      cyc(0, 0, 0, 0, 0, 0, 1, "R5 done");

      // random blocks
      for (int b = 0; b < 80; b++) begin
         set_cfg(2'($urandom), 2'($urandom), 2'($urandom), ($urandom % 4) == 0);
         for (int w = 0; w < 2; w++)
            if ($urandom % 2) cyc(1, w[0], $urandom, 0, $urandom, $urandom, 0, "R9 idle write");
         cyc(0, $urandom, 0, 1, 0, 0, 0, "R2 rnd start");
         for (int k = 0; k < 1 + ($urandom % 8); k++) begin
            if ($urandom % 4 == 0) set_cfg(2'($urandom), 2'($urandom), 2'($urandom), $urandom);
            cyc($urandom % 3 == 0, $urandom, $urandom, $urandom % 5 == 0,
                $urandom, $urandom, 0, "R6 rnd step");
         end
         cyc(0, $urandom, 0, 0, $urandom, $urandom, 1, "R7 rnd done");
      end
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule